// File: doc/BRIEF.md
# Two-Wire Serial Memory Read Slave

This block is the slave side of a two-wire (I2C-style) serial memory for the read path. It watches an open-drain clock line and data line, which it samples with a faster system clock. It recognises start and stop conditions and checks the slave address byte against a fixed device type code and a set of select pins. It acknowledges a matching address and then serves one of several read flows. A master writes two word address bytes with the direction bit low (a dummy write). It can then issue a repeated start to read from that address, or a stop to leave the address in the internal counter for a later read that supplies no address.

Read data comes from a byte array through a synchronous read port: the block presents an address and takes the byte one system clock later. The block shifts bytes out most significant bit first and changes the data line only while the clock is low. It keeps sending successive bytes for as long as the master acknowledges them. The address counter steps past the top of the array back to zero. After a stop, or after an address that does not match, the block stays silent until the next start condition.

Top module: `i2crd_read_slave`

## Requirements
- R1: The slave address byte is matched as bits [7:4] = 4'b1010 and bits [3:1] = `dev_sel_i`, with bit 0 the direction (1 = read). A match is acknowledged by pulling SDA low in the ninth clock. A mismatch gets no acknowledge and the slave ignores the bus until the next start.
- R2: With direction 0, the slave acknowledges two word address bytes, high byte first. The address becomes {high byte[4:0], low byte}, and bits [7:5] of the high byte are ignored.
- R3: A repeated start after the second word address byte, followed by a read address byte, returns the byte stored at the written address.
- R4: A stop after the second word address byte performs no transfer and only loads the address counter. The next read that supplies no address starts from that address.
- R5: After a stop, clock pulses and data bits without a start condition get no acknowledge, never pull SDA low, and leave the address counter unchanged.
- R6: A read address byte right after a start returns data from the address counter. The counter advances by one after every byte sent, so a new read continues one past the last byte transferred.
- R7: When the master acknowledges a data byte (SDA low in the ninth clock), the slave sends the byte at the next address.
- R8: When the master does not acknowledge a data byte, the slave releases SDA and does not drive it again until a start condition, even while clock pulses continue.
- R9: The address counter steps from the top address 0x1FFF to 0x0000 within a sequential read and keeps supplying data.
- R10: The SDA pull-down enable changes only while SCL is low.
- R11: After reset, SDA is released and the address counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_sel_i | input | 3 | Device select value compared with address bits [3:1] |
| scl_i | input | 1 | Sampled level of the serial clock line |
| sda_i | input | 1 | Sampled level of the serial data line |
| sda_drive_o | output | 1 | High to pull the data line low (open-drain) |
| mem_addr_o | output | ADDR_W | Read address to the byte array (address counter) |
| mem_rdata_i | input | 8 | Byte from the array, valid one clock after the address |

## Verification
The assertions check the properties that hold on every cycle. The pull-down enable changes only with SCL low, SDA is never driven in standby or after a master's not-acknowledge, the counter holds still in standby, a matching address is always acknowledged, and the counter wraps from the top address to zero. Only the bench scenarios can show the end-to-end results. These are whether the bytes returned belong to the right addresses across random, current and sequential reads. They also include whether a stop after the word address leaves the counter at the loaded value, whether the ignored upper address bits really drop out, and whether a mismatched address or clocking without a start leaves the counter where it was.

// File: rtl/i2crd_pkg.sv
package i2crd_pkg;

   localparam int          BYTE_W   = 8;
   localparam int          SEL_W    = 3;
   localparam logic [3:0]  DEV_TYPE = 4'b1010;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DEV,
      ST_DEV_ACK,
      ST_WA_HI,
      ST_WA_HI_ACK,
      ST_WA_LO,
      ST_WA_LO_ACK,
      ST_HOLD,
      ST_TX,
      ST_TX_ACK,
      ST_WAIT_STOP
   } rd_state_t;

endpackage

// File: rtl/i2crd_bus_cond.sv
module i2crd_bus_cond #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_lv,
   output logic sda_lv,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic [SYNC_STAGES-1:0] scl_q;
   logic [SYNC_STAGES-1:0] sda_q;
   logic                   scl_prev;
   logic                   sda_prev;

   generate
      for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  scl_q[0] <= 1'b1;
                  sda_q[0] <= 1'b1;
               end else begin
                  scl_q[0] <= scl_i;
                  sda_q[0] <= sda_i;
               end
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  scl_q[g] <= 1'b1;
                  sda_q[g] <= 1'b1;
               end else begin
                  scl_q[g] <= scl_q[g-1];
                  sda_q[g] <= sda_q[g-1];
               end
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_prev <= 1'b1;
         sda_prev <= 1'b1;
      end else begin
         scl_prev <= scl_lv;
         sda_prev <= sda_lv;
      end
   end

   assign scl_lv    = scl_q[SYNC_STAGES-1];
   assign sda_lv    = sda_q[SYNC_STAGES-1];
   assign scl_rise  = scl_lv & ~scl_prev;
   assign scl_fall  = ~scl_lv & scl_prev;
   assign start_det = scl_lv & scl_prev & sda_prev & ~sda_lv;
   assign stop_det  = scl_lv & scl_prev & ~sda_prev & sda_lv;

endmodule

// File: rtl/i2crd_byte_io.sv
module i2crd_byte_io
   import i2crd_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              scl_rise,
   input  logic              sda_lv,
   input  logic              tx_load,
   input  logic              tx_shift,
   input  logic [BYTE_W-1:0] tx_data,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              full,
   output logic              tx_next
);

   localparam int CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

   logic [CNT_W-1:0]  cnt_q;
   logic [BYTE_W-1:0] rx_q;
   logic [BYTE_W-1:0] tx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         rx_q  <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (scl_rise && cnt_q != CNT_FULL) begin
         cnt_q <= cnt_q + 1'b1;
         rx_q  <= {rx_q[BYTE_W-2:0], sda_lv};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q <= '0;
      end else if (tx_load) begin
         tx_q <= tx_data;
      end else if (tx_shift) begin
         tx_q <= {tx_q[BYTE_W-2:0], 1'b1};
      end
   end

   assign rx_byte = rx_q;
   assign full    = (cnt_q == CNT_FULL);
   assign tx_next = tx_q[BYTE_W-2];

endmodule

// File: rtl/i2crd_addr_ctr.sv
module i2crd_addr_ctr #(
   parameter int ADDR_W = 13,
   parameter int DEPTH  = 8192
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              inc,
   output logic [ADDR_W-1:0] addr
);

   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

   logic [ADDR_W-1:0] cnt_q;
   logic [ADDR_W-1:0] nxt;

   generate
      if (DEPTH == (1 << ADDR_W)) begin : g_pow2
         assign nxt = cnt_q + 1'b1;
      end else begin : g_cmp
         assign nxt = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (load) cnt_q <= load_val;
      else if (inc)  cnt_q <= nxt;
   end

   assign addr = cnt_q;

endmodule

// File: rtl/i2crd_read_slave.sv
module i2crd_read_slave
   import i2crd_pkg::*;
#(
   parameter int ADDR_W      = 13,
   parameter int DEPTH       = 8192,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  dev_sel_i,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_drive_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   input  logic [BYTE_W-1:0] mem_rdata_i
);

   localparam int HI_W = ADDR_W - BYTE_W;

   generate
      if (ADDR_W <= BYTE_W || ADDR_W > 2 * BYTE_W) begin : g_bad_addr_w
         $error("ADDR_W must fit two word address bytes and exceed one");
      end
      if (DEPTH < 2 || DEPTH > (1 << ADDR_W)) begin : g_bad_depth
         $error("DEPTH must lie within the address range");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic scl_lv, sda_lv, scl_rise, scl_fall, start_det, stop_det;
   logic [BYTE_W-1:0] rx_byte;
   logic              full;
   logic              tx_next;
   rd_state_t         st_q;
   logic              oe_q;
   logic              rw_q;
   logic              ack_q;
   logic [HI_W-1:0]   hi_q;
   logic              quiet;
   logic              byte_clr;
   logic              tx_load;
   logic              tx_shift;
   logic              ctr_inc;
   logic              ctr_load;
   logic              addr_match;
   logic [ADDR_W-1:0] load_val;

   i2crd_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_i),
      .sda_i    (sda_i),
      .scl_lv   (scl_lv),
      .sda_lv   (sda_lv),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_det(start_det),
      .stop_det (stop_det)
   );

   assign quiet      = ~start_det & ~stop_det;
   assign byte_clr   = start_det |
                       (scl_fall & (st_q == ST_DEV_ACK || st_q == ST_WA_HI_ACK ||
                                    st_q == ST_WA_LO_ACK || st_q == ST_TX_ACK));
   assign tx_load    = quiet & scl_fall &
                       ((st_q == ST_DEV_ACK && rw_q) || (st_q == ST_TX_ACK && ack_q));
   assign tx_shift   = quiet & scl_fall & (st_q == ST_TX) & ~full;
   assign ctr_inc    = quiet & scl_fall & (st_q == ST_TX) & full;
   assign ctr_load   = quiet & scl_fall & (st_q == ST_WA_LO) & full;
   assign addr_match = (rx_byte[BYTE_W-1:1] == {DEV_TYPE, dev_sel_i});
   assign load_val   = {hi_q, rx_byte};

   i2crd_byte_io u_io (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (byte_clr),
      .scl_rise(scl_rise),
      .sda_lv  (sda_lv),
      .tx_load (tx_load),
      .tx_shift(tx_shift),
      .tx_data (mem_rdata_i),
      .rx_byte (rx_byte),
      .full    (full),
      .tx_next (tx_next)
   );

   i2crd_addr_ctr #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (ctr_load),
      .load_val(load_val),
      .inc     (ctr_inc),
      .addr    (mem_addr_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         oe_q  <= 1'b0;
         rw_q  <= 1'b0;
         ack_q <= 1'b0;
         hi_q  <= '0;
      end else if (stop_det) begin
         st_q <= ST_IDLE;
         oe_q <= 1'b0;
      end else if (start_det) begin
         st_q <= ST_DEV;
         oe_q <= 1'b0;
      end else begin
         unique case (st_q)
            ST_DEV: begin
               if (scl_fall && full) begin
                  if (addr_match) begin
                     st_q <= ST_DEV_ACK;
                     oe_q <= 1'b1;
                     rw_q <= rx_byte[0];
                  end else begin
                     st_q <= ST_IDLE;
                  end
               end
            end
            ST_DEV_ACK: begin
               if (scl_fall) begin
                  if (rw_q) begin
                     st_q <= ST_TX;
                     oe_q <= ~mem_rdata_i[BYTE_W-1];
                  end else begin
                     st_q <= ST_WA_HI;
                     oe_q <= 1'b0;
                  end
               end
            end
            ST_WA_HI: begin
               if (scl_fall && full) begin
                  hi_q <= rx_byte[HI_W-1:0];
                  st_q <= ST_WA_HI_ACK;
                  oe_q <= 1'b1;
               end
            end
            ST_WA_HI_ACK: begin
               if (scl_fall) begin
                  st_q <= ST_WA_LO;
                  oe_q <= 1'b0;
               end
            end
            ST_WA_LO: begin
               if (scl_fall && full) begin
                  st_q <= ST_WA_LO_ACK;
                  oe_q <= 1'b1;
               end
            end
            ST_WA_LO_ACK: begin
               if (scl_fall) begin
                  st_q <= ST_HOLD;
                  oe_q <= 1'b0;
               end
            end
            ST_TX: begin
               if (scl_fall) begin
                  if (full) begin
                     st_q <= ST_TX_ACK;
                     oe_q <= 1'b0;
                  end else begin
                     oe_q <= ~tx_next;
                  end
               end
            end
            ST_TX_ACK: begin
               if (scl_rise) begin
                  ack_q <= ~sda_lv;
               end
               if (scl_fall) begin
                  if (ack_q) begin
                     st_q <= ST_TX;
                     oe_q <= ~mem_rdata_i[BYTE_W-1];
                  end else begin
                     st_q <= ST_WAIT_STOP;
                  end
               end
            end
            default: begin
               oe_q <= 1'b0;
            end
         endcase
      end
   end

   assign sda_drive_o = oe_q;

endmodule

// File: rtl/i2crd_read_slave_chk.sv
module i2crd_read_slave_chk
   import i2crd_pkg::*;
#(
   parameter int ADDR_W = 13,
   parameter int DEPTH  = 8192
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_lv,
   input logic              sda_drive,
   input rd_state_t         st,
   input logic              ctr_inc,
   input logic              ctr_load,
   input logic [ADDR_W-1:0] addr
);

   localparam logic [ADDR_W-1:0] TOP = ADDR_W'(DEPTH - 1);

   a_r10_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_drive) |-> !scl_lv);

   a_r5_standby_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> !sda_drive);

   a_r5_standby_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && $past(st) == ST_IDLE) |-> $stable(addr));

   a_r8_nack_released: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT_STOP) |-> !sda_drive);

   a_r1_match_acked: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DEV_ACK && $past(st) == ST_DEV) |-> sda_drive);

   a_r9_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ctr_inc) && !$past(ctr_load) && $past(addr) == TOP) |-> (addr == '0));

endmodule

bind i2crd_read_slave i2crd_read_slave_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl_lv   (scl_lv),
   .sda_drive(sda_drive_o),
   .st       (st_q),
   .ctr_inc  (ctr_inc),
   .ctr_load (ctr_load),
   .addr     (mem_addr_o)
);

// File: tb/i2crd_read_slave_tb.sv
module i2crd_read_slave_tb;

   localparam int CLK_PERIOD = 10;
   localparam int T          = 8;
   localparam int ADDR_W     = 13;
   localparam int NV         = 6;
   // each entry: [23:8] start address, [7:0] byte count
   localparam logic [23:0] VEC [NV] = '{
      24'h0000_03, 24'h0123_02, 24'h1FFE_04,
      24'h0AAA_01, 24'h1000_03, 24'h07FF_02
   };
   localparam logic [2:0] SEL = 3'b010;
   localparam logic [7:0] AW  = {4'b1010, SEL, 1'b0};
   localparam logic [7:0] AR  = {4'b1010, SEL, 1'b1};

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              scl_m = 1'b1;
   logic              sda_m = 1'b1;
   logic              sda_drive;
   logic [ADDR_W-1:0] mem_addr;
   logic [7:0]        mem_rdata;
   logic              sda_line;
   int                n_run = 0;
   int                n_fail = 0;
   int                drv_cnt = 0;
   int                viol = 0;
   logic              drv_prev = 1'b0;
   logic              scl_prev = 1'b1;
   bit                done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign sda_line = sda_m & ~sda_drive;

   i2crd_read_slave u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .dev_sel_i  (SEL),
      .scl_i      (scl_m),
      .sda_i      (sda_line),
      .sda_drive_o(sda_drive),
      .mem_addr_o (mem_addr),
      .mem_rdata_i(mem_rdata)
   );

   function automatic logic [7:0] pat(input logic [ADDR_W-1:0] a);
      return a[7:0] ^ {a[12:8], 3'b000} ^ 8'h5A;
   endfunction

   always @(posedge clk) mem_rdata <= pat(mem_addr);

   always @(negedge clk) begin
      if (sda_drive) drv_cnt++;
      if (sda_drive != drv_prev && scl_m && scl_prev) viol++;
      drv_prev = sda_drive;
      scl_prev = scl_m;
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(T); scl_m = 1'b1; tick(T);
      sda_m = 1'b0; tick(T); scl_m = 1'b0; tick(T);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(T); scl_m = 1'b1; tick(T);
      sda_m = 1'b1; tick(T);
   endtask

   task automatic put_bit(input logic b);
      sda_m = b; tick(T); scl_m = 1'b1; tick(2*T); scl_m = 1'b0; tick(T);
   endtask

   task automatic get_bit(output logic b);
      sda_m = 1'b1; tick(T); scl_m = 1'b1; tick(T);
      b = sda_line; tick(T); scl_m = 1'b0; tick(T);
   endtask

   task automatic put_byte(input logic [7:0] v, output logic ack_n);
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      get_bit(ack_n);
   endtask

   task automatic get_byte(input logic master_ack_n, output logic [7:0] v);
      for (int i = 7; i >= 0; i--) get_bit(v[i]);
      put_bit(master_ack_n);
   endtask

   task automatic set_addr(input logic [15:0] a, input string req);
      logic an;
      bus_start();
      put_byte(AW, an);      chk(an == 1'b0, {req, " addr ack"}, an, 0);
      put_byte(a[15:8], an); chk(an == 1'b0, {req, " hi ack"}, an, 0);
      put_byte(a[7:0], an);  chk(an == 1'b0, {req, " lo ack"}, an, 0);
   endtask

   task automatic read_run(input logic [ADDR_W-1:0] a, input int n, input string req);
      logic an;
      logic [7:0] d;
      put_byte(AR, an); chk(an == 1'b0, {req, " read ack"}, an, 0);
      for (int i = 0; i < n; i++) begin
         get_byte((i == n - 1), d);
         chk(d == pat(a + ADDR_W'(i)), req, d, pat(a + ADDR_W'(i)));
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_run++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic an;
      logic [7:0] d;
      int dc;
      tick(4);
      // R11: reset state
      chk(sda_drive == 1'b0, "R11 drive", sda_drive, 0);
      chk(mem_addr == '0, "R11 counter", mem_addr, 0);
      rst_n = 1'b1;
      tick(4);

      // R2 R3 R7 R9: random reads with sequential bytes from the table
      for (int v = 0; v < NV; v++) begin
         set_addr(VEC[v][23:8], "R2");
         bus_start();
         read_run(VEC[v][8+ADDR_W-1:8], int'(VEC[v][7:0]), "R3 R7 R9 data");
         bus_stop();
      end

      // R6: current address read continues after last byte (0x07FF+2)
      bus_start(); read_run(13'h0801, 1, "R6 current"); bus_stop();

      // R1: wrong select bits and wrong type get no ack
      bus_start(); put_byte({4'b1010, 3'b100, 1'b1}, an);
      chk(an == 1'b1, "R1 select mismatch", an, 1); bus_stop();
      bus_start(); put_byte({4'b1011, SEL, 1'b1}, an);
      chk(an == 1'b1, "R1 type mismatch", an, 1); bus_stop();
      bus_start(); read_run(13'h0802, 1, "R1 R6 counter kept"); bus_stop();

      // R4: stop after word address only loads the counter
      set_addr(16'h0FF0, "R4"); bus_stop();
      bus_start(); read_run(13'h0FF0, 2, "R4 R7 set addr"); bus_stop();

      // R2: upper bits of the high byte ignored
      set_addr(16'hF234, "R2"); bus_stop();
      bus_start(); read_run(13'h1234, 1, "R2 masked"); bus_stop();

      // R5: clocking without a start is ignored
      dc = drv_cnt;
      scl_m = 1'b0; tick(T);
      put_byte(AR, an);
      chk(an == 1'b1, "R5 no ack", an, 1);
      get_byte(1'b1, d);
      chk(d == 8'hFF, "R5 bus idle", d, 8'hFF);
      chk(drv_cnt == dc, "R5 never driven", drv_cnt - dc, 0);
      bus_stop();
      bus_start(); read_run(13'h1235, 1, "R5 counter kept"); 

      // R8: after master nack further clocks see a released line
      dc = drv_cnt;
      get_byte(1'b1, d);
      chk(d == 8'hFF, "R8 released", d, 8'hFF);
      chk(drv_cnt == dc, "R8 no drive", drv_cnt - dc, 0);
      bus_stop();

      // R9: wrap through current address read
      set_addr(16'h1FFF, "R9"); bus_stop();
      bus_start(); read_run(13'h1FFF, 3, "R9 wrap"); bus_stop();
      chk(mem_addr == 13'h0002, "R9 counter after wrap", mem_addr, 2);

      // R10: drive changes only with SCL low
      chk(viol == 0, "R10 drive vs scl", viol, 0);

      // R11: reset in mid-run returns to reset state
      set_addr(16'h0456, "R11"); bus_stop();
      rst_n = 1'b0; tick(3);
      chk(mem_addr == '0, "R11 counter cleared", mem_addr, 0);
      chk(sda_drive == 1'b0, "R11 released", sda_drive, 0);
      rst_n = 1'b1; tick(4);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule